// File: doc/BRIEF.md
# Shared-Bus Ownership Agent

One copy of this agent sits in every node that shares an external bus with up to seven other nodes and a host. Each node drives a single active-low request line, picked by its node number. Every copy watches the full set of request lines on the same clock edge and keeps its own copy of the current owner. Because every copy applies the same rule to the same inputs, all copies reach the same answer and no central arbiter is needed. Lines that belong to absent nodes sit high, so a high line reads as "no request".

Ownership moves only at a transaction boundary. A boundary is a cycle where the shared done strobe pulses, or a cycle where no transaction is in flight. Nodes of equal rank take turns in rotating order, starting with the node after the current owner. Two shared rank lines let a slave's core access, or its high-rank DMA, push aside a master that is only moving normal DMA traffic: a pending request of lower rank pulls its line back while a higher rank line is raised.

A host can claim the bus. The owning node grants it at the next boundary and keeps the grant up until the host lets go, after which the previous owner resumes. A shared lock line stops every hand-over, including the hand-over to the host. The one exception is a back-off strobe, which takes the bus from the owner at once when the host is asking for it.

Top module: `mp_bus_agent`

## Requirements
- R1: The agent pulls `req_n_o` low (active-low, 0 = requesting) exactly when a local request is pending and not withdrawn under R12. A high bit in `req_n_i` is read as an absent or idle node.
- R2: During reset `master_o` and `host_gnt_oe_o` are 0. The node with ID 0 is the owner after reset. No node is master before the first clock edge after reset release, and node 0 is master from that edge on.
- R3: The owner changes only at a boundary edge, where `xfer_done_i`=1 or `xfer_busy_i`=0. At any other edge it holds.
- R4: At a boundary edge, the new owner is the first requesting node in the order current ID+1, +2, … (modulo 8), with the current owner itself checked last.
- R5: If no request line is low at a boundary edge, the current owner keeps the bus.
- R6: While `lock_line_i`=1, ownership does not change and the host is not granted at a boundary.
- R7: With `host_req_i`=1, the owner finishes its transaction. At the next boundary edge it drops `master_o` and raises `host_gnt_o`.
- R8: `host_gnt_o` stays 1 while `host_req_i` stays 1. At the edge where the host request is seen low, the grant drops and the previous owner is master again.
- R9: `backoff_i`=1 together with `host_req_i`=1 hands the bus to the host at the next edge, even mid-transaction and even when locked. `backoff_i` alone has no effect.
- R10: `host_gnt_oe_o` is 1 only in the node whose ID equals the owner. Every other node leaves the grant undriven.
- R11: `core_pri_o` is 1 while a local core request is pending. `dma_pri_o` is 1 while a local high-rank DMA request is pending and no core request is pending.
- R12: Ranks are core > high-rank DMA > normal. A pending request whose rank is below the highest rank line raised (`core_pri_i` or `dma_pri_i`) is withdrawn (`req_n_o`=1).
- R13: `lock_o` is 1 exactly when this node is master and `loc_lock_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| node_id_i | input | 3 | Node number; constant outside reset |
| loc_req_i | input | 1 | Local side wants the bus |
| loc_core_i | input | 1 | Pending request is a core access |
| loc_hipri_i | input | 1 | Pending request is high-rank DMA |
| loc_lock_i | input | 1 | Local side wants the bus locked |
| xfer_busy_i | input | 1 | Shared: a transaction is in flight |
| xfer_done_i | input | 1 | Shared: transaction-done strobe |
| req_n_i | input | 8 | All request lines, active low |
| req_n_o | output | 1 | This node's request line, active low |
| host_req_i | input | 1 | Host wants the bus |
| host_gnt_o | output | 1 | Host grant value |
| host_gnt_oe_o | output | 1 | Drive enable for the host grant |
| backoff_i | input | 1 | Forces the owner off for the host |
| core_pri_i | input | 1 | Shared core-rank line |
| core_pri_o | output | 1 | Drive for core-rank line |
| dma_pri_i | input | 1 | Shared high-rank DMA line |
| dma_pri_o | output | 1 | Drive for high-rank DMA line |
| lock_line_i | input | 1 | Shared lock line |
| lock_o | output | 1 | Drive for lock line |
| master_o | output | 1 | This node owns the bus |

## Verification
Ownership, the host grant and its enable are registered, so they reflect a boundary, host request or back-off one edge after the stimulus. The request line, the rank-line drives and `lock_o` follow their inputs in the same cycle, on top of the ownership state of that cycle. The driver applies each stimulus at a falling edge and queues the outputs expected once the next rising edge has passed. The monitor compares them 5 ns after that rising edge, so every registered result is read exactly one edge after its cause and every combinational result is read under settled inputs.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Ranks of a bus request; larger value wins.
  typedef enum logic [1:0] {
    RANK_NORM = 2'd0,
    RANK_DMA  = 2'd1,
    RANK_CORE = 2'd2
  } rank_e;
endpackage

// File: rtl/arb_rank.sv
module arb_rank
  import arb_pkg::*;
(
  input  logic loc_req_i,
  input  logic loc_core_i,
  input  logic loc_hipri_i,
  input  logic core_line_i,
  input  logic dma_line_i,
  output logic req_act_o,
  output logic core_drv_o,
  output logic dma_drv_o
);
  rank_e own_rank, bus_rank;

  always_comb begin
    if (loc_core_i)       own_rank = RANK_CORE;
    else if (loc_hipri_i) own_rank = RANK_DMA;
    else                  own_rank = RANK_NORM;
    if (core_line_i)      bus_rank = RANK_CORE;
    else if (dma_line_i)  bus_rank = RANK_DMA;
    else                  bus_rank = RANK_NORM;
  end

  assign req_act_o  = loc_req_i && (own_rank >= bus_rank);
  assign core_drv_o = loc_req_i && loc_core_i;
  assign dma_drv_o  = loc_req_i && loc_hipri_i && !loc_core_i;

  // R12: a lower-rank request never shows while a higher line is up
  always_comb begin
    if (core_line_i && !loc_core_i)
      a_r12_withdraw: assert (!req_act_o);
  end
endmodule

// File: rtl/arb_rotate.sv
module arb_rotate #(
  parameter int NODES = 8,
  localparam int IDW = $clog2(NODES)
) (
  input  logic [IDW-1:0]   cur_i,
  input  logic [NODES-1:0] reqs_i,
  output logic [IDW-1:0]   nxt_o
);
  int idx;

  // Walk from farthest to nearest so the nearest requester wins.
  always_comb begin
    nxt_o = cur_i;
    idx   = 0;
    for (int k = NODES; k >= 1; k--) begin
      idx = (int'(cur_i) + k) % NODES;
      if (reqs_i[idx]) nxt_o = IDW'(idx);
    end
  end

  // R5: with nobody requesting the owner is kept
  always_comb begin
    if (reqs_i == '0)
      a_r5_park: assert (nxt_o == cur_i);
  end
endmodule

// File: rtl/arb_host.sv
module arb_host (
  input  logic clk,
  input  logic rst_n,
  input  logic started_i,
  input  logic host_req_i,
  input  logic edge_ok_i,
  input  logic backoff_i,
  output logic host_own_o
);
  logic own_q, own_d;

  always_comb begin
    if (own_q) own_d = host_req_i;
    else       own_d = started_i && host_req_i && (edge_ok_i || backoff_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= 1'b0;
    else        own_q <= own_d;
  end

  assign host_own_o = own_q;

  a_r8_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q && host_req_i) |=> own_q);
  a_r9_backoff_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (started_i && host_req_i && backoff_i) |=> own_q);
endmodule

// File: rtl/mp_bus_agent.sv
module mp_bus_agent #(
  parameter int NODES = 8,
  localparam int IDW = $clog2(NODES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDW-1:0]   node_id_i,
  input  logic             loc_req_i,
  input  logic             loc_core_i,
  input  logic             loc_hipri_i,
  input  logic             loc_lock_i,
  input  logic             xfer_busy_i,
  input  logic             xfer_done_i,
  input  logic [NODES-1:0] req_n_i,
  output logic             req_n_o,
  input  logic             host_req_i,
  output logic             host_gnt_o,
  output logic             host_gnt_oe_o,
  input  logic             backoff_i,
  input  logic             core_pri_i,
  output logic             core_pri_o,
  input  logic             dma_pri_i,
  output logic             dma_pri_o,
  input  logic             lock_line_i,
  output logic             lock_o,
  output logic             master_o
);
  logic [IDW-1:0] cur_q, cur_d, pick;
  logic           started_q, started_d;
  logic           host_own, req_act, boundary, edge_ok, upd, is_owner;

  arb_rank u_rank (
    .loc_req_i   (loc_req_i),
    .loc_core_i  (loc_core_i),
    .loc_hipri_i (loc_hipri_i),
    .core_line_i (core_pri_i),
    .dma_line_i  (dma_pri_i),
    .req_act_o   (req_act),
    .core_drv_o  (core_pri_o),
    .dma_drv_o   (dma_pri_o)
  );

  arb_rotate #(.NODES(NODES)) u_rot (
    .cur_i  (cur_q),
    .reqs_i (~req_n_i),
    .nxt_o  (pick)
  );

  assign boundary = xfer_done_i || !xfer_busy_i;
  assign edge_ok  = boundary && !lock_line_i;

  arb_host u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .started_i  (started_q),
    .host_req_i (host_req_i),
    .edge_ok_i  (edge_ok),
    .backoff_i  (backoff_i),
    .host_own_o (host_own)
  );

  // next-state
  always_comb begin
    started_d = 1'b1;
    upd       = started_q && edge_ok && !host_req_i && !host_own;
    cur_d     = upd ? pick : cur_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= '0;
      started_q <= 1'b0;
    end else begin
      cur_q     <= cur_d;
      started_q <= started_d;
    end
  end

  assign is_owner      = started_q && (cur_q == node_id_i);
  assign master_o      = is_owner && !host_own;
  assign host_gnt_oe_o = is_owner;
  assign host_gnt_o    = is_owner && host_own;
  assign req_n_o       = !req_act;
  assign lock_o        = master_o && loc_lock_i;

  a_r2_no_early_master: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |-> (!master_o && !host_gnt_oe_o));
  a_r3_hold_mid_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy_i && !xfer_done_i) |=> $stable(cur_q));
  a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lock_line_i |=> $stable(cur_q));
  a_r10_drive_only_owner: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt_o |-> host_gnt_oe_o);
endmodule

// File: tb/sim_mp_bus_agent.sv
`timescale 1ns/1ps
module sim_mp_bus_agent;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] node_id;
  logic lreq, lcore, lhi, llock, busy, done, hreq, boff;
  logic ext_c, ext_d, ext_l;
  logic [7:0] others, req_bus;
  logic req_n_o, gnt, gnt_oe, cp_o, dp_o, lk_o, mst;
  int errors = 0, checks = 0;
  bit finished = 0;

  typedef struct {
    logic [6:0] v;   // {mst, oe, gnt, req_n, lock, cpri, dpri}
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;   // 50 MHz

  always_comb begin
    req_bus = others;
    req_bus[node_id] = req_n_o;
  end

  mp_bus_agent u0 (
    .clk(clk), .rst_n(rst_n), .node_id_i(node_id),
    .loc_req_i(lreq), .loc_core_i(lcore), .loc_hipri_i(lhi), .loc_lock_i(llock),
    .xfer_busy_i(busy), .xfer_done_i(done),
    .req_n_i(req_bus), .req_n_o(req_n_o),
    .host_req_i(hreq), .host_gnt_o(gnt), .host_gnt_oe_o(gnt_oe),
    .backoff_i(boff),
    .core_pri_i(ext_c | cp_o), .core_pri_o(cp_o),
    .dma_pri_i(ext_d | dp_o), .dma_pri_o(dp_o),
    .lock_line_i(ext_l | lk_o), .lock_o(lk_o),
    .master_o(mst)
  );

  function automatic logic [6:0] outs();
    return {mst, gnt_oe, gnt, req_n_o, lk_o, cp_o, dp_o};
  endfunction

  task automatic cmp(input logic [6:0] e, input string tag);
    checks++;
    if (outs() !== e) begin
      errors++;
      $display("FAIL %s: got {m,oe,g,rq,lk,cp,dp}=%b expected %b", tag, outs(), e);
    end
  endtask

  // driver: queue what must be visible after the next rising edge
  task automatic push(input logic [6:0] e, input string tag);
    exp_t x;
    x.v = e; x.tag = tag;
    q.push_back(x);
  endtask

  // monitor
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      cmp(x.v, x.tag);
    end
  end

  task automatic idle_inputs();
    lreq = 0; lcore = 0; lhi = 0; llock = 0; busy = 0; done = 0;
    hreq = 0; boff = 0; ext_c = 0; ext_d = 0; ext_l = 0; others = 8'hFF;
  endtask

  initial begin
    #(20.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; node_id = 3'd3; idle_inputs();
    repeat (3) @(negedge clk);
    cmp(7'b0001000, "R2 reset state");
    rst_n = 1;
    push(7'b0001000, "R2 first edge, owner is 0");
    @(negedge clk); lreq = 1; busy = 1;
    push(7'b0000000, "R3 no handover mid transfer");
    @(negedge clk); done = 1;
    push(7'b1100000, "R4 node 3 wins from owner 0");
    @(negedge clk); done = 0; llock = 1; others = 8'hDF;
    push(7'b1100100, "R13 lock out while master");
    @(negedge clk); done = 1;
    push(7'b1100100, "R6 locked owner keeps bus");
    @(negedge clk); llock = 0;
    push(7'b0000000, "R4 rotate 3 to 5");
    @(negedge clk); others = 8'hBD;
    push(7'b0000000, "R4 rotate 5 to 6");
    @(negedge clk);
    push(7'b0000000, "R4 rotate 6 to 1 wrapping");
    @(negedge clk);
    push(7'b1100000, "R4 rotate 1 to 3");
    @(negedge clk); lreq = 0; others = 8'hFF;
    push(7'b1101000, "R5 R1 no requests, owner parks");
    @(negedge clk); others = 8'hFE; busy = 0; done = 0;
    push(7'b0001000, "R3 idle boundary hands to 0");
    @(negedge clk); lreq = 1; others = 8'hFF;
    push(7'b1100000, "R1 R4 back to node 3");
    @(negedge clk); lreq = 0; hreq = 1; busy = 1;
    push(7'b1101000, "R7 host waits for boundary");
    @(negedge clk); done = 1;
    push(7'b0111000, "R7 R10 host granted at boundary");
    @(negedge clk); done = 0; busy = 0; lreq = 1; others = 8'hFE;
    push(7'b0110000, "R8 grant held while host requests");
    @(negedge clk); hreq = 0; lreq = 0; others = 8'hFF; busy = 1;
    push(7'b1101000, "R8 previous owner resumes");
    @(negedge clk); boff = 1;
    push(7'b1101000, "R9 back-off alone has no effect");
    @(negedge clk); boff = 0; llock = 1;
    push(7'b1101100, "R13 lock raised");
    @(negedge clk); hreq = 1; boff = 1;
    push(7'b0111000, "R9 back-off beats lock mid transfer");
    @(negedge clk); hreq = 0; boff = 0; llock = 0;
    push(7'b1101000, "R8 grant released");
    @(negedge clk); lreq = 1; lcore = 1;
    push(7'b1100010, "R11 core line driven");
    @(negedge clk); lcore = 0; lhi = 1;
    push(7'b1100001, "R11 dma line driven");
    @(negedge clk); lcore = 1;
    push(7'b1100010, "R11 core overrides dma drive");
    @(negedge clk); lcore = 0; lhi = 0; ext_c = 1;
    push(7'b1101000, "R12 normal withdrawn under core");
    @(negedge clk); lhi = 1;
    push(7'b1101001, "R12 dma withdrawn under core");
    @(negedge clk); ext_c = 0; ext_d = 1;
    push(7'b1100001, "R12 dma stays under dma line");
    @(negedge clk); lhi = 0;
    push(7'b1101000, "R12 normal withdrawn under dma");
    @(negedge clk); idle_inputs();
    push(7'b1101000, "R1 idle again");
    repeat (3) @(negedge clk);
    rst_n = 0; node_id = 3'd0;
    @(negedge clk);
    cmp(7'b0001000, "R2 second reset state");
    rst_n = 1;
    push(7'b1101000, "R2 node 0 master after first edge");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule